// File: doc/BRIEF.md
# Microcode Sequencer with Handshaked Unit Dispatch

This block walks a fixed program of 32-bit macro-instructions held in a small read-only program store. It reads one word per cycle through a combinational ROM read port. It decodes the opcode in the top nibble and hands the work to exactly one of several datapath units. The hand-off is a one-cycle start pulse on that unit's strobe, and the two operand fields are presented alongside it. The units share a single scratchpad, so only one of them may run at a time. The sequencer therefore holds its program counter until the unit it started reports completion, and only then fetches the next word.

A start pulse launches the program from address zero. Opcode zero ends the program: fetching stops and a finished flag stays high until the next start pulse. Opcodes that map to no unit cost one cycle and do nothing else. Completion signals are accepted only from the unit that was started, and only after its start cycle.

Top module: `ucode_seq`

## Requirements
- R1: After reset, `finished` is 0, `act_start` is all zero and `rom_addr` is 0, and no unit is started until `start` is pulsed.
- R2: A `start` pulse sampled while idle or halted puts address 0 on `rom_addr` in the next cycle. The first unit start appears two cycles after the cycle in which `start` was high.
- R3: The opcode is bits [31:28] of `rom_data`. Opcode k, for 1 ≤ k ≤ N_ACT, raises `act_start[k-1]` alone, for exactly one cycle, in the cycle after the fetch.
- R4: `act_src` carries bits [27:16] and `act_dst` carries bits [15:0] of the fetched word. Both are valid while the start pulse is high and are held until the unit's done is accepted.
- R5: After a start, the program counter holds until the started unit raises its done bit. The next unit start follows L+2 cycles after the previous one, where L is the number of cycles from start to done.
- R6: A done bit raised by the started unit in the same cycle as its start pulse is ignored.
- R7: Done bits from units other than the started one never advance the program counter.
- R8: Opcode 0 raises `finished` in the cycle after it is fetched. `finished` then stays high and no unit is started until the next `start`. That `start` clears `finished` in the next cycle and reruns the program from address 0.
- R9: An opcode above N_ACT (7 to 15 with the default N_ACT of 6) starts no unit and advances to the next address after one cycle.
- R10: A `start` pulse arriving while a program is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch the program from address 0 |
| rom_addr | output | PC_W | Program store read address |
| rom_data | input | 32 | Instruction word at `rom_addr`, same cycle |
| act_start | output | N_ACT | One-hot, one-cycle start strobes, one per unit |
| act_src | output | 12 | Source operand field for the started unit |
| act_dst | output | 16 | Destination/length operand field for the started unit |
| act_done | input | N_ACT | Completion strobes, one per unit |
| finished | output | 1 | High after a halt opcode until the next start |

## Verification
The hardest cases to reach from the ports are completion strobes that arrive when they must be ignored. One is a done bit that coincides with the start pulse. The other is a done bit from a unit that is idle. The bench's unit stubs can optionally echo done in the start cycle, or assert done on every unit not currently started, in every cycle. Program completion time is then compared with the latency-derived figure, so any early advance shows up as a shorter run.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
    parameter int INSTR_W = 32;
    parameter int OPC_W   = 4;
    parameter int SRC_W   = 12;
    parameter int DST_W   = 16;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_WAIT  = 2'd2,
        S_HALT  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/ucode_seq_decode.sv
module ucode_seq_decode
    import ucode_seq_pkg::*;
#(
    parameter int N_ACT = 6,
    parameter int SEL_W = 3
) (
    input  logic [OPC_W-1:0] opcode,
    output logic             is_halt,
    output logic             is_act,
    output logic [N_ACT-1:0] hit,
    output logic [SEL_W-1:0] idx
);
    // one comparator per unit; opcode k+1 selects unit k
    for (genvar k = 0; k < N_ACT; k++) begin : g_hit
        assign hit[k] = (opcode == OPC_W'(k + 1));
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < N_ACT; k++) begin
            if (hit[k]) idx = SEL_W'(k);
        end
        is_act  = |hit;
        is_halt = (opcode == '0);
    end
endmodule

// File: rtl/ucode_seq_done_sel.sv
module ucode_seq_done_sel #(
    parameter int N_ACT = 6,
    parameter int SEL_W = 3
) (
    input  logic [N_ACT-1:0] done,
    input  logic [SEL_W-1:0] sel,
    output logic             sel_done
);
    always_comb begin
        sel_done = 1'b0;
        for (int k = 0; k < N_ACT; k++) begin
            if (sel == SEL_W'(k)) sel_done = done[k];
        end
    end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_seq_pkg::*;
#(
    parameter int N_ACT = 6,
    parameter int PC_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [PC_W-1:0]    rom_addr,
    input  logic [INSTR_W-1:0] rom_data,
    output logic [N_ACT-1:0]   act_start,
    output logic [SRC_W-1:0]   act_src,
    output logic [DST_W-1:0]   act_dst,
    input  logic [N_ACT-1:0]   act_done,
    output logic               finished
);
    localparam int SEL_W   = (N_ACT > 1) ? $clog2(N_ACT) : 1;
    localparam int SRC_LSB = DST_W;
    localparam int OPC_LSB = DST_W + SRC_W;

    typedef struct packed {
        seq_state_e       state;
        logic [PC_W-1:0]  pc;
        logic [N_ACT-1:0] start_vec;
        logic [SEL_W-1:0] sel;
        logic [SRC_W-1:0] src;
        logic [DST_W-1:0] dst;
        logic             finished;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             dec_halt;
    logic             dec_act;
    logic [N_ACT-1:0] dec_hit;
    logic [SEL_W-1:0] dec_idx;
    logic             sel_done;

    ucode_seq_decode #(.N_ACT(N_ACT), .SEL_W(SEL_W)) u_decode (
        .opcode  (rom_data[OPC_LSB +: OPC_W]),
        .is_halt (dec_halt),
        .is_act  (dec_act),
        .hit     (dec_hit),
        .idx     (dec_idx)
    );

    ucode_seq_done_sel #(.N_ACT(N_ACT), .SEL_W(SEL_W)) u_done_sel (
        .done     (act_done),
        .sel      (seq_q.sel),
        .sel_done (sel_done)
    );

    always_comb begin
        seq_d           = seq_q;
        seq_d.start_vec = '0;
        unique case (seq_q.state)
            S_IDLE, S_HALT: begin
                if (start) begin
                    seq_d.state    = S_FETCH;
                    seq_d.pc       = '0;
                    seq_d.finished = 1'b0;
                end
            end
            S_FETCH: begin
                if (dec_halt) begin
                    seq_d.state    = S_HALT;
                    seq_d.finished = 1'b1;
                end else if (dec_act) begin
                    seq_d.state     = S_WAIT;
                    seq_d.start_vec = dec_hit;
                    seq_d.sel       = dec_idx;
                    seq_d.src       = rom_data[SRC_LSB +: SRC_W];
                    seq_d.dst       = rom_data[0 +: DST_W];
                end else begin
                    seq_d.pc = seq_q.pc + 1'b1;
                end
            end
            S_WAIT: begin
                // the start cycle itself never accepts done
                if (seq_q.start_vec == '0 && sel_done) begin
                    seq_d.state = S_FETCH;
                    seq_d.pc    = seq_q.pc + 1'b1;
                end
            end
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: S_IDLE, pc: '0, start_vec: '0, sel: '0,
                       src: '0, dst: '0, finished: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rom_addr  = seq_q.pc;
    assign act_start = seq_q.start_vec;
    assign act_src   = seq_q.src;
    assign act_dst   = seq_q.dst;
    assign finished  = seq_q.finished;

    // R3
    onehot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_start));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_start != '0) |=> (act_start == '0));

    // R6
    done_in_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_start != '0) |=> (seq_q.state == S_WAIT && $stable(rom_addr)));

    // R5
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == S_WAIT && !sel_done) |=> $stable(rom_addr));

    // R4
    operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == S_WAIT && !sel_done) |=> ($stable(act_src) && $stable(act_dst)));

    // R8
    finished_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finished && !start) |=> (finished && act_start == '0));
endmodule

// File: tb/ucode_seq_bench.sv
`timescale 1ns/1ps
module ucode_seq_bench;
    localparam int N_ACT = 6;
    localparam int PC_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [PC_W-1:0]   rom_addr;
    logic [31:0]       rom_data;
    logic [N_ACT-1:0]  act_start;
    logic [11:0]       act_src;
    logic [15:0]       act_dst;
    logic [N_ACT-1:0]  act_done = '0;
    logic              finished;

    logic [31:0] rom [256];
    assign rom_data = rom[rom_addr];

    ucode_seq #(.N_ACT(N_ACT), .PC_W(PC_W)) u_ucode_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .act_start(act_start), .act_src(act_src), .act_dst(act_dst),
        .act_done(act_done), .finished(finished)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    // unit stubs and issue log
    int lat [N_ACT];
    int cnt [N_ACT];
    bit echo  = 1'b0;
    bit noise = 1'b0;
    int n_ev = 0;
    int ev_act [64];
    int ev_src [64];
    int ev_dst [64];
    int ev_cyc [64];

    task automatic chk(input bit ok, input string req, input string what,
                       input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    always @(negedge clk) begin
        logic [N_ACT-1:0] nd;
        nd = '0;
        if (rst_n && act_start != '0 && n_ev < 64) begin
            for (int k = 0; k < N_ACT; k++) if (act_start[k]) ev_act[n_ev] = k;
            ev_src[n_ev] = int'(act_src);
            ev_dst[n_ev] = int'(act_dst);
            ev_cyc[n_ev] = cyc;
            n_ev++;
        end
        for (int k = 0; k < N_ACT; k++) begin
            if (rst_n && act_start[k]) begin
                cnt[k] = lat[k];
                if (echo) nd[k] = 1'b1;
            end else if (cnt[k] > 0) begin
                cnt[k]--;
                if (cnt[k] == 0) begin
                    nd[k] = 1'b1;
                    // R4 operands still held when done is raised
                    chk(int'(act_src) == ev_src[n_ev-1], "R4", "src held", int'(act_src), ev_src[n_ev-1]);
                    chk(int'(act_dst) == ev_dst[n_ev-1], "R4", "dst held", int'(act_dst), ev_dst[n_ev-1]);
                end
            end else if (noise) begin
                nd[k] = 1'b1;
            end
        end
        act_done = nd;
    end

    function automatic logic [31:0] mk(input int op, input int src, input int dst);
        return {4'(op), 12'(src), 16'(dst)};
    endfunction

    task automatic fill_halt();
        for (int i = 0; i < 256; i++) rom[i] = 32'h0;
    endtask

    task automatic pulse_start(output int s);
        @(negedge clk);
        s = cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_fin(output int f);
        int t;
        t = 0;
        f = -1;
        while (!finished && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (finished) f = cyc;
        else chk(1'b0, "R8", "finished timeout", 0, 1);
    endtask

    task automatic prep(input int l0, input int l1, input int l2,
                        input int l3, input int l4, input int l5);
        lat[0] = l0; lat[1] = l1; lat[2] = l2;
        lat[3] = l3; lat[4] = l4; lat[5] = l5;
        @(negedge clk);
        n_ev = 0;
    endtask

    task automatic t_reset();
        fill_halt();
        rom[0] = mk(1, 1, 1);
        for (int k = 0; k < N_ACT; k++) begin lat[k] = 1; cnt[k] = 0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(finished == 1'b0, "R1", "finished after reset", int'(finished), 0);
        chk(act_start == '0, "R1", "act_start after reset", int'(act_start), 0);
        chk(rom_addr == '0, "R1", "rom_addr after reset", int'(rom_addr), 0);
        repeat (6) @(negedge clk);
        chk(n_ev == 0, "R1", "no start while idle", n_ev, 0);
    endtask

    task automatic basic_prog();
        fill_halt();
        rom[0] = mk(1, 'h123, 'hBEEF);
        rom[1] = mk(3, 'h456, 'h0010);
        rom[2] = mk(6, 'hFFF, 'h8001);
        rom[3] = mk(0, 0, 0);
    endtask

    task automatic t_basic();
        int s, f;
        basic_prog();
        prep(1, 2, 3, 4, 5, 6);
        pulse_start(s);
        chk(rom_addr == '0, "R2", "rom_addr after start", int'(rom_addr), 0);
        wait_fin(f);
        chk(n_ev == 3, "R3", "issue count", n_ev, 3);
        chk(ev_cyc[0] == s + 2, "R2", "first start cycle", ev_cyc[0], s + 2);
        chk(ev_act[0] == 0, "R3", "unit of op1", ev_act[0], 0);
        chk(ev_act[1] == 2, "R3", "unit of op3", ev_act[1], 2);
        chk(ev_act[2] == 5, "R3", "unit of op6", ev_act[2], 5);
        chk(ev_src[0] == 'h123, "R4", "src field", ev_src[0], 'h123);
        chk(ev_dst[0] == 'hBEEF, "R4", "dst field", ev_dst[0], 'hBEEF);
        chk(ev_src[2] == 'hFFF, "R4", "src field max", ev_src[2], 'hFFF);
        chk(ev_dst[2] == 'h8001, "R4", "dst field", ev_dst[2], 'h8001);
        chk(ev_cyc[1] - ev_cyc[0] == 3, "R5", "gap lat1", ev_cyc[1] - ev_cyc[0], 3);
        chk(ev_cyc[2] - ev_cyc[1] == 5, "R5", "gap lat3", ev_cyc[2] - ev_cyc[1], 5);
        chk(f == ev_cyc[2] + 8, "R8", "finish cycle", f, ev_cyc[2] + 8);
        repeat (6) @(negedge clk);
        chk(finished == 1'b1, "R8", "finished held", int'(finished), 1);
        chk(n_ev == 3, "R8", "no start after halt", n_ev, 3);
    endtask

    task automatic t_nop();
        int s, f;
        fill_halt();
        rom[0] = mk(2, 'h011, 'h0022);
        rom[1] = mk(9, 0, 0);
        rom[2] = mk(15, 'hFFF, 'hFFFF);
        rom[3] = mk(7, 0, 0);
        rom[4] = mk(1, 'h033, 'h0044);
        rom[5] = mk(0, 0, 0);
        prep(1, 2, 1, 1, 1, 1);
        pulse_start(s);
        wait_fin(f);
        chk(n_ev == 2, "R9", "no-op issues nothing", n_ev, 2);
        chk(ev_act[1] == 0, "R9", "unit after no-ops", ev_act[1], 0);
        chk(ev_cyc[1] - ev_cyc[0] == 7, "R9", "no-op one cycle each", ev_cyc[1] - ev_cyc[0], 7);
        chk(f == ev_cyc[1] + 3, "R9", "finish after no-ops", f, ev_cyc[1] + 3);
    endtask

    task automatic t_echo();
        int s, f;
        fill_halt();
        rom[0] = mk(4, 'h0AA, 'h5555);
        rom[1] = mk(0, 0, 0);
        prep(1, 1, 1, 6, 1, 1);
        echo = 1'b1;
        pulse_start(s);
        wait_fin(f);
        echo = 1'b0;
        chk(n_ev == 1, "R6", "issue count", n_ev, 1);
        chk(ev_act[0] == 3, "R6", "unit of op4", ev_act[0], 3);
        chk(f == ev_cyc[0] + 8, "R6", "done in start cycle ignored", f, ev_cyc[0] + 8);
    endtask

    task automatic t_noise();
        int s, f;
        fill_halt();
        rom[0] = mk(2, 'h100, 'h0200);
        rom[1] = mk(5, 'h300, 'h0400);
        rom[2] = mk(0, 0, 0);
        prep(1, 2, 1, 1, 5, 1);
        noise = 1'b1;
        pulse_start(s);
        wait_fin(f);
        noise = 1'b0;
        chk(n_ev == 2, "R7", "issue count", n_ev, 2);
        chk(ev_cyc[1] - ev_cyc[0] == 4, "R7", "foreign done ignored", ev_cyc[1] - ev_cyc[0], 4);
        chk(f == ev_cyc[1] + 7, "R7", "foreign done ignored at end", f, ev_cyc[1] + 7);
    endtask

    task automatic t_restart();
        int s, s2, f;
        basic_prog();
        prep(1, 2, 3, 4, 5, 6);
        pulse_start(s);
        chk(finished == 1'b0, "R8", "start clears finished", int'(finished), 0);
        while (n_ev == 0) @(negedge clk);
        pulse_start(s2);
        wait_fin(f);
        chk(n_ev == 3, "R10", "start while running ignored", n_ev, 3);
        chk(ev_act[1] == 2, "R10", "program order kept", ev_act[1], 2);
        chk(f == ev_cyc[0] + 16, "R10", "run length unchanged", f, ev_cyc[0] + 16);
    endtask

    initial begin
        #(10ns * 150000);
        chk(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_nop();
        t_echo();
        t_noise();
        t_restart();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule